// File: doc/BRIEF.md
# Bus Security Gate for Peripheral Slots and SRAM Pages

This block sits between requesters and a bus fabric and decides, one access at a time, whether the access may go on. Each access arrives with an address, a valid strobe, a read/write flag and the security state of the requester. The block works out whether the address hits an SRAM page, a peripheral slot, its own configuration window or nothing at all. For pages and slots it looks up a single protection bit. A set bit marks the target Secure and a cleared bit marks it Non-Secure.

A Secure requester always gets through. A Non-Secure requester gets through only to a target whose bit is cleared. When an access is refused, the block withholds the downstream strobe and write enable and returns zero read data. One cycle later it raises a single-cycle fault and captures the address that caused it.

The protection bits sit in 32-bit configuration words inside the block. Only Secure requesters may read or write these words. At reset every bit is set, so the whole space starts out Secure.

Top module: `sec_gate`

## Requirements
- R1: After reset, every slot and page bit is 1. A Secure read of word 0 returns 0x0000FFFF, a Secure read of words 1 to 3 returns 0xFFFFFFFF, and `fault` is 0.
- R2: The address map is as follows. Page p covers byte addresses p*256 to p*256+255, for p from 0 to 95. Slot s covers 0x8000+s*256 to 0x8000+s*256+255, for s from 0 to 15. Configuration word w sits at 0xF000+4*w, for w from 0 to 3. Bit s of word 0 is slot s. Word 0 bits 31:16 read as 0 and ignore writes.
- R3: A Non-Secure access to a slot or page whose bit is 0 is forwarded. `dn_valid` is 1, `dn_write` equals `acc_write`, and `acc_rdata` equals `dn_rdata`.
- R4: A Non-Secure access to a slot or page whose bit is 1 is blocked. `dn_valid` and `dn_write` are 0, and `acc_rdata` is 0.
- R5: Page i is controlled by bit i%32 of configuration word 1+i/32.
- R6: A Secure access to any slot or page is forwarded whatever its bit.
- R7: A blocked access in cycle n makes `fault` 1 in cycle n+1 only, unless cycle n+1 also carries a blocked access. `fault_addr` takes the blocked address at the same edge and holds it until the next blocked access.
- R8: A Secure write to a configuration word takes effect at the next clock edge. A read in the following cycle returns the new value, masked as in R2.
- R9: A Non-Secure access to the configuration window is blocked. A write leaves every bit unchanged, a read returns 0, and both raise the fault as in R7.
- R10: An address outside pages, slots and configuration words is treated as Secure. A Non-Secure access to it is blocked, and a Secure access to it is forwarded.
- R11: An access to the configuration window is never forwarded, so `dn_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_secure | input | 1 | Requester is Secure when 1 |
| acc_write | input | 1 | Write when 1, read when 0 |
| acc_addr | input | 16 | Byte address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data returned to the requester |
| dn_valid | output | 1 | Forwarded strobe |
| dn_write | output | 1 | Forwarded write enable |
| dn_addr | output | 16 | Forwarded address |
| dn_wdata | output | 32 | Forwarded write data |
| dn_rdata | input | 32 | Read data from the target |
| fault | output | 1 | Single-cycle security fault |
| fault_addr | output | 16 | Address of the most recent blocked access |

## Verification
The assertions assume that the access inputs hold known values from the first clock edge after reset and change only between edges. They also assume at most one access per cycle, with the configuration word selected purely by address. The checks that compare against the previous cycle, such as the captured fault address and unchanged bits after a refused configuration write, depend on those inputs being steady at the sampling edge. The bench drives every input on the falling edge, keeps `acc_valid` low between scenarios and releases reset before the first access, so the stimulus stays within these assumptions.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_SRAM   = 2'd1,
    TGT_PERIPH = 2'd2,
    TGT_CFG    = 2'd3
  } tgt_e;

  // Page i lives in page word i/32 (configuration word 1 + i/32), bit i%32.
  function automatic int page_word(input int idx);
    return idx / 32;
  endfunction

  function automatic int page_bit(input int idx);
    return idx % 32;
  endfunction
endpackage

// File: rtl/sg_decode.sv
module sg_decode
  import sg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_LOG2   = 8,
  parameter int NUM_PAGES   = 96,
  parameter int NUM_PERIPH  = 16,
  parameter int SLOT_LOG2   = 8,
  parameter int PERIPH_BASE = 32'h8000,
  parameter int CFG_BASE    = 32'hF000,
  parameter int NUM_CFG     = 4,
  parameter int IDX_W       = 7,
  parameter int CW_W        = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  idx,
  output logic [CW_W-1:0]   cfg_word
);
  localparam logic [ADDR_W-1:0] SRAM_END = ADDR_W'(NUM_PAGES * (1 << PAGE_LOG2));
  localparam logic [ADDR_W-1:0] P_LO     = ADDR_W'(PERIPH_BASE);
  localparam logic [ADDR_W-1:0] P_HI     = ADDR_W'(PERIPH_BASE + NUM_PERIPH * (1 << SLOT_LOG2));
  localparam logic [ADDR_W-1:0] C_LO     = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] C_HI     = ADDR_W'(CFG_BASE + 4 * NUM_CFG);

  logic [ADDR_W-1:0] p_off, c_off;
  assign p_off = addr - P_LO;
  assign c_off = addr - C_LO;

  always_comb begin
    tgt      = TGT_NONE;
    idx      = '0;
    cfg_word = '0;
    if (addr < SRAM_END) begin
      tgt = TGT_SRAM;
      idx = IDX_W'(addr >> PAGE_LOG2);
    end else if (addr >= P_LO && addr < P_HI) begin
      tgt = TGT_PERIPH;
      idx = IDX_W'(p_off >> SLOT_LOG2);
    end else if (addr >= C_LO && addr < C_HI) begin
      tgt      = TGT_CFG;
      cfg_word = CW_W'(c_off >> 2);
    end
  end
endmodule

// File: rtl/sg_cfg_regs.sv
module sg_cfg_regs
  import sg_pkg::*;
#(
  parameter int NUM_PAGES  = 96,
  parameter int NUM_PERIPH = 16,
  parameter int IDX_W      = 7,
  parameter int CW_W       = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [CW_W-1:0]                 word_sel,
  input  logic [31:0]                     wr_data,
  output logic [31:0]                     rd_data,
  input  logic [IDX_W-1:0]                idx,
  output logic                            page_sec,
  output logic                            slot_sec,
  output logic [NUM_PAGES+NUM_PERIPH-1:0] cfg_flat
);
  logic [NUM_PAGES-1:0]  page_q;
  logic [NUM_PERIPH-1:0] slot_q;

  for (genvar s = 0; s < NUM_PERIPH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[s] <= 1'b1;
      else if (wr_en && word_sel == '0) slot_q[s] <= wr_data[s];
    end
  end

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    localparam int WORD = 1 + page_word(p);
    localparam int BIT  = page_bit(p);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) page_q[p] <= 1'b1;
      else if (wr_en && word_sel == CW_W'(WORD)) page_q[p] <= wr_data[BIT];
    end
  end

  always_comb begin
    rd_data = '0;
    if (word_sel == '0) begin
      for (int s = 0; s < NUM_PERIPH; s++) rd_data[s] = slot_q[s];
    end
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (word_sel == CW_W'(1 + page_word(p))) rd_data[page_bit(p)] = page_q[p];
    end
  end

  always_comb begin
    page_sec = 1'b1;
    slot_sec = 1'b1;
    for (int p = 0; p < NUM_PAGES; p++)
      if (idx == IDX_W'(p)) page_sec = page_q[p];
    for (int s = 0; s < NUM_PERIPH; s++)
      if (idx == IDX_W'(s)) slot_sec = slot_q[s];
  end

  assign cfg_flat = {page_q, slot_q};
endmodule

// File: rtl/sg_gate.sv
module sg_gate
  import sg_pkg::*;
(
  input  logic valid,
  input  logic secure,
  input  logic write,
  input  tgt_e tgt,
  input  logic page_sec,
  input  logic slot_sec,
  output logic blocked,
  output logic fwd,
  output logic cfg_wr
);
  logic target_secure;
  logic allow;

  always_comb begin
    unique case (tgt)
      TGT_SRAM:   target_secure = page_sec;
      TGT_PERIPH: target_secure = slot_sec;
      default:    target_secure = 1'b1;
    endcase
  end

  assign allow   = secure || !target_secure;
  assign blocked = valid && !allow;
  assign fwd     = valid && allow && (tgt != TGT_CFG);
  assign cfg_wr  = valid && secure && write && (tgt == TGT_CFG);
endmodule

// File: rtl/sg_fault.sv
module sg_fault #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blocked,
  input  logic [ADDR_W-1:0] addr,
  output logic              fault,
  output logic [ADDR_W-1:0] fault_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault      <= 1'b0;
      fault_addr <= '0;
    end else begin
      fault <= blocked;
      if (blocked) fault_addr <= addr;
    end
  end
endmodule

// File: rtl/sec_gate.sv
module sec_gate
  import sg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_LOG2   = 8,
  parameter int NUM_PAGES   = 96,
  parameter int NUM_PERIPH  = 16,
  parameter int SLOT_LOG2   = 8,
  parameter int PERIPH_BASE = 32'h8000,
  parameter int CFG_BASE    = 32'hF000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_secure,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata,
  output logic              fault,
  output logic [ADDR_W-1:0] fault_addr
);
  localparam int PAGE_WORDS = (NUM_PAGES + 31) / 32;
  localparam int NUM_CFG    = 1 + PAGE_WORDS;
  localparam int CW_W       = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;
  localparam int IDX_MAX    = (NUM_PAGES > NUM_PERIPH) ? NUM_PAGES : NUM_PERIPH;
  localparam int IDX_W      = (IDX_MAX > 1) ? $clog2(IDX_MAX) : 1;
  localparam int CFG_BITS   = NUM_PAGES + NUM_PERIPH;

  tgt_e                tgt;
  logic [IDX_W-1:0]    idx;
  logic [CW_W-1:0]     cfg_word;
  logic [31:0]         cfg_rd;
  logic                page_sec, slot_sec;
  logic                blocked, fwd, cfg_wr;
  logic                is_cfg;
  logic [CFG_BITS-1:0] cfg_flat;

  sg_decode #(
    .ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2), .NUM_PAGES(NUM_PAGES),
    .NUM_PERIPH(NUM_PERIPH), .SLOT_LOG2(SLOT_LOG2), .PERIPH_BASE(PERIPH_BASE),
    .CFG_BASE(CFG_BASE), .NUM_CFG(NUM_CFG), .IDX_W(IDX_W), .CW_W(CW_W)
  ) i_decode (
    .addr(acc_addr), .tgt(tgt), .idx(idx), .cfg_word(cfg_word)
  );

  sg_cfg_regs #(
    .NUM_PAGES(NUM_PAGES), .NUM_PERIPH(NUM_PERIPH), .IDX_W(IDX_W), .CW_W(CW_W)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .word_sel(cfg_word),
    .wr_data(acc_wdata), .rd_data(cfg_rd), .idx(idx),
    .page_sec(page_sec), .slot_sec(slot_sec), .cfg_flat(cfg_flat)
  );

  sg_gate i_gate (
    .valid(acc_valid), .secure(acc_secure), .write(acc_write), .tgt(tgt),
    .page_sec(page_sec), .slot_sec(slot_sec),
    .blocked(blocked), .fwd(fwd), .cfg_wr(cfg_wr)
  );

  sg_fault #(.ADDR_W(ADDR_W)) i_fault (
    .clk(clk), .rst_n(rst_n), .blocked(blocked), .addr(acc_addr),
    .fault(fault), .fault_addr(fault_addr)
  );

  assign is_cfg    = (tgt == TGT_CFG);
  assign dn_valid  = fwd;
  assign dn_write  = fwd && acc_write;
  assign dn_addr   = acc_addr;
  assign dn_wdata  = acc_wdata;
  assign acc_rdata = blocked ? 32'h0 : (is_cfg ? cfg_rd : dn_rdata);
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int ADDR_W   = 16,
  parameter int CFG_BITS = 112
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acc_valid,
  input logic                acc_secure,
  input logic                acc_write,
  input logic [ADDR_W-1:0]   acc_addr,
  input logic [31:0]         acc_rdata,
  input logic                dn_valid,
  input logic                dn_write,
  input logic                fault,
  input logic [ADDR_W-1:0]   fault_addr,
  input logic                blocked,
  input logic                is_cfg,
  input logic [CFG_BITS-1:0] cfg_flat
);
  p_block_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (!dn_valid && !dn_write && acc_rdata == 32'h0));

  p_secure_passes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_secure && !is_cfg) |-> dn_valid);

  p_fault_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> (fault && fault_addr == $past(acc_addr)));

  p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !blocked |=> (!fault && $stable(fault_addr)));

  p_ns_cfg_write_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_secure && acc_write && is_cfg) |=> $stable(cfg_flat));

  p_cfg_local_r11: assert property (@(posedge clk) disable iff (!rst_n)
    is_cfg |-> !dn_valid);
endmodule

bind sec_gate sg_checker #(.ADDR_W(ADDR_W), .CFG_BITS(CFG_BITS)) i_checker (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_secure(acc_secure),
  .acc_write(acc_write), .acc_addr(acc_addr), .acc_rdata(acc_rdata),
  .dn_valid(dn_valid), .dn_write(dn_write), .fault(fault),
  .fault_addr(fault_addr), .blocked(blocked), .is_cfg(is_cfg),
  .cfg_flat(cfg_flat)
);

// File: tb/test_sec_gate.sv
module test_sec_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_secure = 1'b0, acc_write = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0, dn_rdata = '0;
  logic [31:0] acc_rdata, dn_wdata;
  logic        dn_valid, dn_write, fault;
  logic [15:0] dn_addr, fault_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_slot;
  logic [95:0] m_page;

  always #5 clk = ~clk;

  sec_gate i_sec_gate (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_secure(acc_secure),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .dn_valid(dn_valid), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
    .fault(fault), .fault_addr(fault_addr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Bench view of the map: 0 none, 1 page, 2 slot, 3 config word.
  function automatic int kind(input logic [15:0] a);
    if (a < 16'h6000) return 1;
    if (a >= 16'h8000 && a < 16'h9000) return 2;
    if (a >= 16'hF000 && a < 16'hF010) return 3;
    return 0;
  endfunction

  function automatic bit tgt_secure(input logic [15:0] a);
    case (kind(a))
      1: return m_page[a / 256];
      2: return m_slot[(a - 16'h8000) / 256];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] cfg_word(input int w);
    if (w == 0) return {16'h0, m_slot};
    return m_page[(w - 1) * 32 +: 32];
  endfunction

  task automatic access(input logic [15:0] a, input bit sec, input bit wr,
                        input logic [31:0] wd, input string req);
    bit pass, cfg;
    logic [31:0] exp_rd;
    pass = sec || !tgt_secure(a);
    cfg  = (kind(a) == 3);
    exp_rd = !pass ? 32'h0 : (cfg ? cfg_word((a - 16'hF000) / 4) : (32'hC0DE0000 | a));
    @(negedge clk);
    acc_addr = a; acc_secure = sec; acc_write = wr; acc_wdata = wd;
    acc_valid = 1'b1; dn_rdata = 32'hC0DE0000 | a;
    #1;
    chk(req, "dn_valid", dn_valid, pass && !cfg);
    chk(req, "dn_write", dn_write, pass && !cfg && wr);
    if (!wr) chk(req, "acc_rdata", acc_rdata, exp_rd);
    @(negedge clk);
    acc_valid = 1'b0;
    chk(req, "fault", fault, !pass);
    if (!pass) chk(req, "fault_addr", fault_addr, a);
    if (pass && cfg && wr) begin
      if (a[3:2] == 2'd0) m_slot = wd[15:0];
      else m_page[(a[3:2] - 1) * 32 +: 32] = wd;
    end
  endtask

  task automatic t_reset_r1;
    chk("R1", "fault after reset", fault, 0);
    access(16'hF000, 1, 0, 0, "R1");
    chk("R1", "word0", acc_rdata, 32'h0000FFFF);
    access(16'hF004, 1, 0, 0, "R1");
    access(16'hF008, 1, 0, 0, "R1");
    access(16'hF00C, 1, 0, 0, "R1");
    access(16'h8300, 0, 0, 0, "R1 slot blocked");
    access(16'h0010, 0, 1, 32'h1, "R1 page blocked");
  endtask

  task automatic t_slots_r3_r4;
    access(16'hF000, 1, 1, 32'hFFFFFF5A, "R8 slot word write");
    access(16'hF000, 1, 0, 0, "R2 upper bits");
    chk("R2", "word0 readback", acc_rdata, 32'h0000FF5A);
    access(16'h8000, 0, 0, 0, "R3 slot0 read");
    access(16'h8020, 0, 1, 32'h55, "R3 slot0 write");
    access(16'h8510, 0, 0, 0, "R3 slot5");
    access(16'h8100, 0, 1, 32'h7, "R4 slot1 write");
    access(16'h81FF, 0, 0, 0, "R4 slot1 read");
    access(16'h8FFC, 0, 0, 0, "R4 slot15");
  endtask

  task automatic t_pages_r5;
    access(16'hF008, 1, 1, ~(32'h1 << 5), "R8 page word1");
    access(16'hF004, 1, 1, 32'hFFFFFFFE, "R8 page word0");
    access(16'hF00C, 1, 1, 32'h7FFFFFFF, "R8 page word2");
    access(16'hF008, 1, 0, 0, "R8 readback");
    access(16'h2510, 0, 0, 0, "R5 page37 open");
    access(16'h2400, 0, 1, 32'h9, "R5 page36 shut");
    access(16'h4500, 0, 0, 0, "R5 page69 shut");
    access(16'h0000, 0, 1, 32'h3, "R5 page0 open");
    access(16'h5FFF, 0, 0, 0, "R5 page95 open");
    access(16'h5E00, 0, 0, 0, "R5 page94 shut");
  endtask

  task automatic t_secure_r6;
    access(16'h2400, 1, 1, 32'hAB, "R6 secure page write");
    access(16'h8100, 1, 0, 0, "R6 secure slot read");
    access(16'h2510, 1, 0, 0, "R6 secure to open page");
  endtask

  task automatic t_fault_r7;
    @(negedge clk);
    acc_valid = 1; acc_secure = 0; acc_write = 0; acc_addr = 16'h8100;
    @(negedge clk);
    chk("R7", "fault 1st", fault, 1);
    chk("R7", "addr 1st", fault_addr, 16'h8100);
    acc_addr = 16'h2400;
    @(negedge clk);
    chk("R7", "fault 2nd", fault, 1);
    chk("R7", "addr 2nd", fault_addr, 16'h2400);
    acc_addr = 16'h8000;
    @(negedge clk);
    acc_valid = 0;
    chk("R7", "fault drops", fault, 0);
    chk("R7", "addr held", fault_addr, 16'h2400);
    @(negedge clk);
    chk("R7", "fault stays low", fault, 0);
  endtask

  task automatic t_ns_cfg_r9;
    access(16'hF000, 0, 1, 32'h0, "R9 ns cfg write");
    access(16'hF004, 0, 0, 0, "R9 ns cfg read");
    access(16'hF000, 1, 0, 0, "R9 unchanged");
    chk("R9", "word0 kept", acc_rdata, 32'h0000FF5A);
    access(16'h8100, 0, 0, 0, "R9 slot1 still shut");
  endtask

  task automatic t_unmapped_r10_r11;
    access(16'h6000, 0, 0, 0, "R10 past sram ns");
    access(16'h9000, 0, 1, 32'h1, "R10 past slots ns");
    access(16'hF010, 0, 0, 0, "R10 past cfg ns");
    access(16'h6000, 1, 1, 32'h2, "R10 past sram secure");
    access(16'hA000, 1, 0, 0, "R10 gap secure");
    access(16'hF00C, 1, 0, 0, "R11 cfg read local");
  endtask

  initial begin
    m_slot = '1;
    m_page = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_slots_r3_r4();
    t_pages_r5();
    t_secure_r6();
    t_fault_r7();
    t_ns_cfg_r9();
    t_unmapped_r10_r11();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule